// File: doc/BRIEF.md
# Virtualized supervisor timer compare unit

This block holds the per-hart supervisor timer compare value and the guest (virtual-supervisor) timer compare value. It compares each one against a free-running 64-bit time count and raises a level-sensitive pending bit while the time has reached the compare value. The guest comparison uses the time count plus a 64-bit guest offset, wrapping modulo 2^64.

A single CSR port carries an address, an operation (read, write, bit-set, bit-clear), write data, the current privilege level and the virtualization flag. The unit decodes each access and applies the privilege rules, raising a trap flag when an access is not allowed. When the hart runs a guest, an access to the supervisor compare address is sent to the guest compare register instead. The unit also holds the hypervisor guest-timer enable, the software-set virtual pending bit and the guest-timer delegation bit. It produces the guest's own view of the timer pending and enable bits, which read as zero or mirror the hypervisor bits, depending on delegation. A pending and enabled guest timer is steered either to the hypervisor or to the guest.

Top module: `vst_timer_unit`

## Requirements
- R1: Both compare registers are 64 bits wide and reset to all ones. After reset neither `s_tip` nor `g_tip` is set, and a read of either compare register from M mode returns all ones.
- R2: `s_tip` is 1 exactly when `time_now` >= the supervisor compare value, unsigned, and is recomputed every cycle. A compare write is visible at the next cycle, so writing a value above the current time clears `s_tip` from that cycle on.
- R3: The guest compare fires when (`time_now` + `guest_delta`) mod 2^64 >= the guest compare value. `g_tip` is the OR of that fire signal and the software virtual pending bit, which is bit 6 of address 0x645.
- R4: With `virt_on`=1 in S mode (VS), an access to the supervisor compare address 0x14D reads and writes the guest compare register (address 0x24D) and leaves the supervisor compare untouched.
- R5: Privilege codes are 0=U, 1=S, 3=M. Address 0x14D traps only from U or VU. Address 0x24D and the hypervisor registers 0x644 (pending), 0x604 (enable), 0x645 (virtual pending) and 0x603 (delegation) trap when `virt_on`=1 or the mode is U. From M, and from S with `virt_on`=0, none of these addresses traps.
- R6: An access that raises `csr_trap` returns zero read data and changes no register.
- R7: With `virt_on`=1, addresses 0x104 (enable) and 0x144 (pending) give the guest view, with the timer bit at bit 5. When delegation bit 6 of 0x603 is 0, that bit reads 0 and writes to it are ignored. When it is 1, bit 5 mirrors the hypervisor guest-timer enable (0x604 bit 6) or `g_tip`, and a write to the guest enable bit updates the hypervisor enable.
- R8: The supervisor timer enable (0x104 bit 5 with `virt_on`=0) and the hypervisor guest-timer enable (0x604 bit 6) are separate flops, and no other bits are stored in them. Writing one never changes the other.
- R9: `g_irq_hs` = `g_tip` & guest enable & !delegation, and `g_irq_vs` = `g_tip` & guest enable & delegation. The two are never set together.
- R10: Operation codes: 0 reads, 1 writes the data, 2 ORs the data into the register, 3 clears the register bits that are set in the data. A read changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | 64 | Free-running time count |
| guest_delta | input | 64 | Offset added to time for the guest comparison |
| priv_mode | input | 2 | Current privilege: 0=U, 1=S, 3=M |
| virt_on | input | 1 | Hart is running a guest |
| csr_req | input | 1 | CSR access valid this cycle |
| csr_op | input | 2 | 0 read, 1 write, 2 set bits, 3 clear bits |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 64 | Write or mask data |
| csr_rdata | output | 64 | Read data, value before the access; zero on trap |
| csr_trap | output | 1 | Access not allowed at this privilege |
| s_tip | output | 1 | Supervisor timer pending |
| g_tip | output | 1 | Hypervisor guest-timer pending |
| g_irq_hs | output | 1 | Guest timer interrupt routed to the hypervisor |
| g_irq_vs | output | 1 | Guest timer interrupt routed to the guest |

## Verification
Two functions can meet in one cycle: a compare register write and the time count sitting exactly on the new compare value. The bench holds `time_now` at a value, then writes that same value into the compare register, and expects the pending bit to rise in the next cycle, judged against the new value. The second such meeting is a guest-view enable write made while delegation is off. Here the bench writes the alias with delegation clear and then reads the hypervisor enable back from M mode, so it can see that the write was dropped.

// File: rtl/vst_pkg.sv
package vst_pkg;

    typedef enum logic [1:0] {
        PRV_U   = 2'd0,
        PRV_S   = 2'd1,
        PRV_RSV = 2'd2,
        PRV_M   = 2'd3
    } prv_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        TGT_NONE,
        TGT_SCMP,
        TGT_GCMP,
        TGT_HPEND,
        TGT_HEN,
        TGT_HVPEND,
        TGT_HDELEG,
        TGT_SEN,
        TGT_SPEND,
        TGT_GEN,
        TGT_GPEND
    } tgt_e;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] A_SEN    = 12'h104;
    localparam logic [ADDR_W-1:0] A_SPEND  = 12'h144;
    localparam logic [ADDR_W-1:0] A_SCMP   = 12'h14D;
    localparam logic [ADDR_W-1:0] A_GCMP   = 12'h24D;
    localparam logic [ADDR_W-1:0] A_HDELEG = 12'h603;
    localparam logic [ADDR_W-1:0] A_HEN    = 12'h604;
    localparam logic [ADDR_W-1:0] A_HPEND  = 12'h644;
    localparam logic [ADDR_W-1:0] A_HVPEND = 12'h645;

    localparam int GT_BIT = 6;
    localparam int ST_BIT = 5;

endpackage

// File: rtl/vst_csr_decode.sv
module vst_csr_decode
    import vst_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        prv_i,
    input  logic              virt_i,
    output tgt_e              tgt_o,
    output logic              trap_o
);
    logic is_lower;
    logic guest_on;
    logic hyp_ok;
    tgt_e tgt_raw;
    logic trap_raw;

    always_comb begin
        is_lower = (prv_i == PRV_U) || (prv_i == PRV_RSV);
        guest_on = virt_i && (prv_i != PRV_M);
        hyp_ok   = !guest_on && !is_lower;
    end

    always_comb begin
        tgt_raw  = TGT_NONE;
        trap_raw = 1'b0;
        unique case (addr_i)
            A_SCMP: begin
                trap_raw = is_lower;
                tgt_raw  = guest_on ? TGT_GCMP : TGT_SCMP;
            end
            A_GCMP: begin
                trap_raw = !hyp_ok;
                tgt_raw  = TGT_GCMP;
            end
            A_HPEND: begin
                trap_raw = !hyp_ok;
                tgt_raw  = TGT_HPEND;
            end
            A_HEN: begin
                trap_raw = !hyp_ok;
                tgt_raw  = TGT_HEN;
            end
            A_HVPEND: begin
                trap_raw = !hyp_ok;
                tgt_raw  = TGT_HVPEND;
            end
            A_HDELEG: begin
                trap_raw = !hyp_ok;
                tgt_raw  = TGT_HDELEG;
            end
            A_SEN: begin
                trap_raw = is_lower;
                tgt_raw  = guest_on ? TGT_GEN : TGT_SEN;
            end
            A_SPEND: begin
                trap_raw = is_lower;
                tgt_raw  = guest_on ? TGT_GPEND : TGT_SPEND;
            end
            default: begin
                trap_raw = 1'b0;
                tgt_raw  = TGT_NONE;
            end
        endcase
    end

    always_comb begin
        trap_o = trap_raw;
        tgt_o  = trap_raw ? TGT_NONE : tgt_raw;
    end

endmodule

// File: rtl/vst_cmp_slot.sv
module vst_cmp_slot #(
    parameter int W          = 64,
    parameter bit USE_OFFSET = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_val_i,
    input  logic [W-1:0] time_i,
    input  logic [W-1:0] offset_i,
    output logic [W-1:0] value_o,
    output logic         fire_o
);
    localparam logic [W-1:0] RESET_VAL = {W{1'b1}};

    logic [W-1:0] cmp_q;
    logic [W-1:0] eff_time;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= RESET_VAL;
        end else if (wr_en_i) begin
            cmp_q <= wr_val_i;
        end
    end

    generate
        if (USE_OFFSET) begin : g_offset
            always_comb eff_time = time_i + offset_i;
        end else begin : g_plain
            logic unused_off;
            always_comb begin
                eff_time   = time_i;
                unused_off = ^offset_i;
            end
        end
    endgenerate

    always_comb begin
        value_o = cmp_q;
        fire_o  = (eff_time >= cmp_q);
    end

endmodule

// File: rtl/vst_irq_route.sv
module vst_irq_route (
    input  logic g_tip_i,
    input  logic g_en_i,
    input  logic deleg_i,
    output logic irq_hs_o,
    output logic irq_vs_o
);
    logic armed;

    always_comb begin
        armed    = g_tip_i && g_en_i;
        irq_hs_o = armed && !deleg_i;
        irq_vs_o = armed && deleg_i;
    end

endmodule

// File: rtl/vst_timer_unit.sv
module vst_timer_unit
    import vst_pkg::*;
#(
    parameter int W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      time_now,
    input  logic [W-1:0]      guest_delta,
    input  logic [1:0]        priv_mode,
    input  logic              virt_on,
    input  logic              csr_req,
    input  logic [1:0]        csr_op,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [W-1:0]      csr_wdata,
    output logic [W-1:0]      csr_rdata,
    output logic              csr_trap,
    output logic              s_tip,
    output logic              g_tip,
    output logic              g_irq_hs,
    output logic              g_irq_vs
);
    tgt_e         tgt;
    logic         trap_raw;
    logic [W-1:0] scmp_val;
    logic [W-1:0] gcmp_val;
    logic         s_fire;
    logic         g_fire;
    logic         sen_q;
    logic         hen_q;
    logic         hvpend_q;
    logic         deleg_q;
    logic [W-1:0] old_val;
    logic [W-1:0] new_val;
    logic         wr_go;
    op_e          op;

    vst_csr_decode u_dec (
        .addr_i (csr_addr),
        .prv_i  (priv_mode),
        .virt_i (virt_on),
        .tgt_o  (tgt),
        .trap_o (trap_raw)
    );

    always_comb begin
        op    = op_e'(csr_op);
        wr_go = csr_req && !trap_raw && (op != OP_READ);
    end

    vst_cmp_slot #(.W(W), .USE_OFFSET(1'b0)) u_scmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_go && (tgt == TGT_SCMP)),
        .wr_val_i (new_val),
        .time_i   (time_now),
        .offset_i ('0),
        .value_o  (scmp_val),
        .fire_o   (s_fire)
    );

    vst_cmp_slot #(.W(W), .USE_OFFSET(1'b1)) u_gcmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_go && (tgt == TGT_GCMP)),
        .wr_val_i (new_val),
        .time_i   (time_now),
        .offset_i (guest_delta),
        .value_o  (gcmp_val),
        .fire_o   (g_fire)
    );

    always_comb begin
        s_tip = s_fire;
        g_tip = g_fire || hvpend_q;
    end

    // Current value of the addressed register, as seen through the access path
    always_comb begin
        old_val = '0;
        unique case (tgt)
            TGT_SCMP:   old_val = scmp_val;
            TGT_GCMP:   old_val = gcmp_val;
            TGT_HPEND:  old_val[GT_BIT] = g_tip;
            TGT_HEN:    old_val[GT_BIT] = hen_q;
            TGT_HVPEND: old_val[GT_BIT] = hvpend_q;
            TGT_HDELEG: old_val[GT_BIT] = deleg_q;
            TGT_SEN:    old_val[ST_BIT] = sen_q;
            TGT_SPEND:  old_val[ST_BIT] = s_tip;
            TGT_GEN:    old_val[ST_BIT] = deleg_q && hen_q;
            TGT_GPEND:  old_val[ST_BIT] = deleg_q && g_tip;
            default:    old_val = '0;
        endcase
    end

    always_comb begin
        unique case (op)
            OP_WRITE: new_val = csr_wdata;
            OP_SET:   new_val = old_val | csr_wdata;
            OP_CLEAR: new_val = old_val & ~csr_wdata;
            default:  new_val = old_val;
        endcase
    end

    always_comb begin
        csr_trap  = csr_req && trap_raw;
        csr_rdata = (csr_req && !trap_raw) ? old_val : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sen_q    <= 1'b0;
            hen_q    <= 1'b0;
            hvpend_q <= 1'b0;
            deleg_q  <= 1'b0;
        end else if (wr_go) begin
            unique case (tgt)
                TGT_SEN:    sen_q    <= new_val[ST_BIT];
                TGT_HEN:    hen_q    <= new_val[GT_BIT];
                TGT_HVPEND: hvpend_q <= new_val[GT_BIT];
                TGT_HDELEG: deleg_q  <= new_val[GT_BIT];
                TGT_GEN: begin
                    if (deleg_q) hen_q <= new_val[ST_BIT];
                end
                default: ;
            endcase
        end
    end

    vst_irq_route u_route (
        .g_tip_i  (g_tip),
        .g_en_i   (hen_q),
        .deleg_i  (deleg_q),
        .irq_hs_o (g_irq_hs),
        .irq_vs_o (g_irq_vs)
    );

endmodule

// File: rtl/vst_timer_checker.sv
module vst_timer_checker
    import vst_pkg::*;
#(
    parameter int W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csr_req,
    input logic              csr_trap,
    input logic [W-1:0]      csr_rdata,
    input logic [1:0]        priv_mode,
    input logic              virt_on,
    input logic [ADDR_W-1:0] csr_addr,
    input logic              hvpend_q,
    input logic              deleg_q,
    input logic              g_tip,
    input logic              g_irq_hs,
    input logic              g_irq_vs,
    input logic [W-1:0]      scmp_val,
    input logic [W-1:0]      gcmp_val
);
    AST_TRAP_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && csr_trap) |-> (csr_rdata == '0)); // R6

    AST_TRAP_HOLDS_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && csr_trap) |=> ($stable(scmp_val) && $stable(gcmp_val))); // R6

    AST_USER_SCMP_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && (priv_mode == 2'd0) && (csr_addr == A_SCMP)) |-> csr_trap); // R5

    AST_GUEST_GCMP_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && virt_on && (priv_mode != 2'd3) && (csr_addr == A_GCMP)) |-> csr_trap); // R5

    AST_VPEND_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        hvpend_q |-> g_tip); // R3

    AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(g_irq_hs && g_irq_vs)); // R9

    AST_GUEST_VIEW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && !csr_trap && virt_on && (priv_mode == 2'd1) &&
         (csr_addr == A_SEN) && !deleg_q) |-> (csr_rdata == '0)); // R7

endmodule

bind vst_timer_unit vst_timer_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_req   (csr_req),
    .csr_trap  (csr_trap),
    .csr_rdata (csr_rdata),
    .priv_mode (priv_mode),
    .virt_on   (virt_on),
    .csr_addr  (csr_addr),
    .hvpend_q  (hvpend_q),
    .deleg_q   (deleg_q),
    .g_tip     (g_tip),
    .g_irq_hs  (g_irq_hs),
    .g_irq_vs  (g_irq_vs),
    .scmp_val  (scmp_val),
    .gcmp_val  (gcmp_val)
);

// File: tb/vst_timer_unit_test.sv
module vst_timer_unit_test;
    localparam int CYCLE = 20;
    localparam logic [11:0] SEN = 12'h104, SPEND = 12'h144, SCMP = 12'h14D,
                            GCMP = 12'h24D, HDELEG = 12'h603, HEN = 12'h604,
                            HPEND = 12'h644, HVPEND = 12'h645;
    localparam logic [1:0] RD = 2'd0, WR = 2'd1, ST = 2'd2, CL = 2'd3;
    localparam logic [1:0] PU = 2'd0, PS = 2'd1, PM = 2'd3;
    localparam logic [63:0] ONES = {64{1'b1}};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_now = '0;
    logic [63:0] guest_delta = '0;
    logic [1:0]  priv_mode = PM;
    logic        virt_on = 1'b0;
    logic        csr_req = 1'b0;
    logic [1:0]  csr_op = RD;
    logic [11:0] csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic        csr_trap, s_tip, g_tip, g_irq_hs, g_irq_vs;

    int n_run = 0;
    int n_fail = 0;
    bit timed_out = 1'b0;

    always #(CYCLE/2) clk = ~clk;

    vst_timer_unit uut (
        .clk(clk), .rst_n(rst_n), .time_now(time_now), .guest_delta(guest_delta),
        .priv_mode(priv_mode), .virt_on(virt_on), .csr_req(csr_req), .csr_op(csr_op),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .csr_trap(csr_trap), .s_tip(s_tip), .g_tip(g_tip),
        .g_irq_hs(g_irq_hs), .g_irq_vs(g_irq_vs)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One CSR access; read data and trap sampled mid-cycle, write lands at the edge
    task automatic acc(input logic [1:0] op, input logic [11:0] a, input logic [63:0] wd,
                       input logic [1:0] prv, input logic v,
                       output logic [63:0] rd, output logic tr);
        @(negedge clk);
        csr_req = 1'b1; csr_op = op; csr_addr = a; csr_wdata = wd;
        priv_mode = prv; virt_on = v;
        #2;
        rd = csr_rdata; tr = csr_trap;
        @(negedge clk);
        csr_req = 1'b0; priv_mode = PM; virt_on = 1'b0;
        #1;
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    task automatic t_reset();
        logic [63:0] rd; logic tr;
        check("R1 s_tip after reset", s_tip, 0);
        check("R1 g_tip after reset", g_tip, 0);
        acc(RD, SCMP, 0, PM, 0, rd, tr);
        check("R1 supervisor compare reset", rd, ONES);
        acc(RD, GCMP, 0, PM, 0, rd, tr);
        check("R1 guest compare reset", rd, ONES);
    endtask

    task automatic t_s_compare();
        logic [63:0] rd; logic tr;
        time_now = 64'd100;
        acc(WR, SCMP, 64'd50, PM, 0, rd, tr);
        check("R2 time above compare", s_tip, 1);
        acc(WR, SCMP, 64'd200, PM, 0, rd, tr);
        check("R2 compare above time clears", s_tip, 0);
        time_now = 64'd199; settle();
        check("R2 one below", s_tip, 0);
        time_now = 64'd200; settle();
        check("R2 equal fires", s_tip, 1);
        time_now = 64'd300;
        acc(WR, SCMP, 64'd300, PM, 0, rd, tr);
        check("R2 write equal to current time", s_tip, 1);
        acc(WR, SCMP, ONES, PM, 0, rd, tr);
    endtask

    task automatic t_g_compare();
        logic [63:0] rd; logic tr;
        time_now = 64'd100; guest_delta = 64'd50;
        acc(WR, GCMP, 64'd150, PM, 0, rd, tr);
        check("R3 offset sum equal fires", g_tip, 1);
        acc(WR, GCMP, 64'd151, PM, 0, rd, tr);
        check("R3 offset sum below", g_tip, 0);
        time_now = 64'hFFFF_FFFF_FFFF_FFF0; guest_delta = 64'h20;
        acc(WR, GCMP, 64'h10, PM, 0, rd, tr);
        check("R3 wrapped sum equal", g_tip, 1);
        acc(WR, GCMP, 64'h11, PM, 0, rd, tr);
        check("R3 wrapped sum below", g_tip, 0);
        acc(WR, HVPEND, 64'h40, PM, 0, rd, tr);
        check("R3 virtual pending ORed", g_tip, 1);
        acc(RD, HPEND, 0, PS, 0, rd, tr);
        check("R3 hypervisor pending bit 6", rd, 64'h40);
        acc(WR, HVPEND, 0, PM, 0, rd, tr);
        check("R3 virtual pending cleared", g_tip, 0);
        acc(WR, GCMP, ONES, PM, 0, rd, tr);
        time_now = 64'd100; guest_delta = 0;
    endtask

    task automatic t_redirect();
        logic [63:0] rd; logic tr;
        acc(WR, SCMP, 64'h1234, PS, 1, rd, tr);
        check("R4 guest write no trap", tr, 0);
        acc(RD, GCMP, 0, PM, 0, rd, tr);
        check("R4 guest write landed in guest compare", rd, 64'h1234);
        acc(RD, SCMP, 0, PM, 0, rd, tr);
        check("R4 supervisor compare untouched", rd, ONES);
        acc(RD, SCMP, 0, PS, 1, rd, tr);
        check("R4 guest read sees guest compare", rd, 64'h1234);
        acc(WR, GCMP, ONES, PM, 0, rd, tr);
    endtask

    task automatic t_privilege();
        logic [63:0] rd; logic tr;
        acc(RD, SCMP, 0, PU, 0, rd, tr);  check("R5 U on supervisor compare", tr, 1);
        acc(RD, SCMP, 0, PU, 1, rd, tr);  check("R5 VU on supervisor compare", tr, 1);
        acc(RD, SCMP, 0, PS, 0, rd, tr);  check("R5 HS on supervisor compare", tr, 0);
        acc(RD, GCMP, 0, PS, 1, rd, tr);  check("R5 VS on guest compare", tr, 1);
        acc(RD, GCMP, 0, PS, 0, rd, tr);  check("R5 HS on guest compare", tr, 0);
        acc(RD, GCMP, 0, PM, 0, rd, tr);  check("R5 M on guest compare", tr, 0);
        acc(RD, HEN, 0, PS, 1, rd, tr);   check("R5 VS on hypervisor enable", tr, 1);
        acc(RD, HDELEG, 0, PU, 0, rd, tr); check("R5 U on delegation", tr, 1);
    endtask

    task automatic t_trap_state();
        logic [63:0] rd; logic tr;
        acc(WR, GCMP, 64'h55, PM, 0, rd, tr);
        acc(WR, GCMP, 64'h7, PS, 1, rd, tr);
        check("R6 trap flag", tr, 1);
        acc(RD, GCMP, 0, PS, 1, rd, tr);
        check("R6 trapped read data zero", rd, 0);
        acc(RD, GCMP, 0, PM, 0, rd, tr);
        check("R6 guest compare unchanged", rd, 64'h55);
        acc(WR, SCMP, 64'h9, PU, 0, rd, tr);
        acc(RD, SCMP, 0, PM, 0, rd, tr);
        check("R6 supervisor compare unchanged", rd, ONES);
        acc(WR, HDELEG, 64'h40, PS, 1, rd, tr);
        acc(RD, HDELEG, 0, PM, 0, rd, tr);
        check("R6 delegation unchanged", rd, 0);
        acc(WR, GCMP, ONES, PM, 0, rd, tr);
    endtask

    task automatic t_alias();
        logic [63:0] rd; logic tr;
        acc(WR, HDELEG, 0, PM, 0, rd, tr);
        acc(WR, HEN, 64'h40, PM, 0, rd, tr);
        acc(RD, SEN, 0, PS, 1, rd, tr);
        check("R7 guest enable reads zero undelegated", rd, 0);
        acc(WR, SEN, 0, PS, 1, rd, tr);
        acc(RD, HEN, 0, PM, 0, rd, tr);
        check("R7 undelegated guest write ignored", rd, 64'h40);
        acc(WR, HVPEND, 64'h40, PM, 0, rd, tr);
        acc(RD, SPEND, 0, PS, 1, rd, tr);
        check("R7 guest pending reads zero undelegated", rd, 0);
        acc(WR, HDELEG, 64'h40, PM, 0, rd, tr);
        acc(RD, SPEND, 0, PS, 1, rd, tr);
        check("R7 guest pending mirrors", rd, 64'h20);
        acc(RD, SEN, 0, PS, 1, rd, tr);
        check("R7 guest enable mirrors", rd, 64'h20);
        acc(WR, SEN, 0, PS, 1, rd, tr);
        acc(RD, HEN, 0, PM, 0, rd, tr);
        check("R7 delegated guest clear reaches hypervisor", rd, 0);
        acc(ST, SEN, 64'h20, PS, 1, rd, tr);
        acc(RD, HEN, 0, PM, 0, rd, tr);
        check("R7 delegated guest set reaches hypervisor", rd, 64'h40);
        acc(WR, HVPEND, 0, PM, 0, rd, tr);
        acc(WR, HEN, 0, PM, 0, rd, tr);
        acc(WR, HDELEG, 0, PM, 0, rd, tr);
    endtask

    task automatic t_separate();
        logic [63:0] rd; logic tr;
        acc(WR, HEN, ONES, PM, 0, rd, tr);
        acc(RD, HEN, 0, PM, 0, rd, tr);
        check("R8 hypervisor enable keeps only bit 6", rd, 64'h40);
        acc(RD, SEN, 0, PM, 0, rd, tr);
        check("R8 supervisor enable untouched", rd, 0);
        acc(WR, SEN, ONES, PS, 0, rd, tr);
        acc(RD, SEN, 0, PM, 0, rd, tr);
        check("R8 supervisor enable keeps only bit 5", rd, 64'h20);
        acc(WR, SEN, 0, PM, 0, rd, tr);
        acc(RD, HEN, 0, PM, 0, rd, tr);
        check("R8 hypervisor enable untouched", rd, 64'h40);
        acc(WR, HEN, 0, PM, 0, rd, tr);
    endtask

    task automatic t_route();
        logic [63:0] rd; logic tr;
        acc(WR, HVPEND, 64'h40, PM, 0, rd, tr);
        check("R9 disabled no route hs", g_irq_hs, 0);
        check("R9 disabled no route vs", g_irq_vs, 0);
        acc(WR, HEN, 64'h40, PM, 0, rd, tr);
        check("R9 undelegated to hs", g_irq_hs, 1);
        check("R9 undelegated not vs", g_irq_vs, 0);
        acc(WR, HDELEG, 64'h40, PM, 0, rd, tr);
        check("R9 delegated not hs", g_irq_hs, 0);
        check("R9 delegated to vs", g_irq_vs, 1);
        acc(WR, HVPEND, 0, PM, 0, rd, tr);
        check("R9 no pending no route", g_irq_vs, 0);
        acc(WR, HEN, 0, PM, 0, rd, tr);
        acc(WR, HDELEG, 0, PM, 0, rd, tr);
    endtask

    task automatic t_ops();
        logic [63:0] rd; logic tr;
        acc(WR, SCMP, 64'h100, PM, 0, rd, tr);
        acc(ST, SCMP, 64'h3, PM, 0, rd, tr);
        check("R10 set returns old value", rd, 64'h100);
        acc(RD, SCMP, 64'hFF, PM, 0, rd, tr);
        check("R10 set result", rd, 64'h103);
        acc(CL, SCMP, 64'h100, PM, 0, rd, tr);
        acc(RD, SCMP, 64'hFF, PM, 0, rd, tr);
        check("R10 clear result, read with data changes nothing", rd, 64'h3);
        acc(WR, SCMP, ONES, PM, 0, rd, tr);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                @(negedge clk); rst_n = 1'b1; #1;
                t_reset();
                t_s_compare();
                t_g_compare();
                t_redirect();
                t_privilege();
                t_trap_state();
                t_alias();
                t_separate();
                t_route();
                t_ops();
            end
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        if (timed_out) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule